// File: doc/BRIEF.md
# Dual-Issue Instruction Dispatch Unit

This block sits between instruction fetch and register read in a two-wide in-order pipeline. Each cycle it receives an aligned pair of 32-bit instructions. Slot 0 holds the older instruction and slot 1 the younger. The block finds the execution unit each instruction targets. It then routes each instruction onto one of two issue paths: the even path serves the arithmetic-style units and the odd path serves permute, branch and memory. In the same cycle it decides whether the pair issues whole, issues only the older instruction, or issues nothing.

Two kinds of conflict can stop an instruction. A structural conflict arises when both instructions need the same path. A read-after-write conflict arises in two ways: a source register is still marked busy in the hazard scoreboard supplied from outside, or the younger instruction reads the register the older one writes. When the pair splits, the unit raises a stall to fetch and remembers in one bit that the older instruction has already left. Fetch keeps presenting the same pair, and the younger instruction goes out in a later cycle. A flush from branch resolution drops the pair and this remembered state. A flag from fetch marks a pair whose first slot must be skipped, as happens when a branch lands on the second slot; that slot is then treated as an empty slot.

Top module: `dual_issue_dispatch`

## Requirements
- R1: Instruction fields are laid out as follows:
  - unit code in bits 31:29;
  - destination register (also the third source) in bits 28:22;
  - first source in bits 21:15;
  - second source in bits 14:8;
  - bit 7 set means the second source is read;
  - bit 6 set means the destination register is also read as a third source;
  - bit 5 set means the instruction writes its destination.
  Unit codes are 1 FX1, 2 FX2, 3 SP, 4 BYTE, 5 PERMUTE, 6 BR, 7 LS, and 0 means an empty slot.
- R2: Units 1 to 4 issue only on the even path and units 5 to 7 only on the odd path. Each issued instruction appears on its path one clock after the decision cycle, carrying its unit code, register indices, source-use flags and write flag.
- R3: A pair whose instructions target different paths and have no hazards issues completely in one cycle, with stall low.
- R4: When both instructions target the same path, the older one issues and stall is high. The younger one issues in the next cycle in which it has no hazards.
- R5: When the younger instruction reads (through any source it uses) the register the older one writes, the pair splits as in R4. If the older instruction does not write, the pair does not split.
- R6: Each source operand an instruction uses is checked against the busy vector. The first source is always used; the second and third sources are used only when their flag is set. An instruction with a busy used source does not issue, and stall stays high. A busy register that is not used has no effect.
- R7: The younger instruction never issues in a cycle in which the older, still-pending instruction does not issue.
- R8: With the skip flag set, slot 0 is treated as empty and slot 1 may issue alone without stall.
- R9: With flush high, nothing issues, stall is low and the split state is cleared. The same pair presented afterwards is decided afresh from its older instruction.
- R10: Empty slots (unit code 0) never issue, and a pair of two empty slots, or an invalid pair, raises no stall.
- R11: After reset both issue paths are invalid and stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Cancel current pair and split state |
| pair_vld | input | 1 | Instruction pair present |
| pair_skip0 | input | 1 | Treat slot 0 as empty |
| pair_ins0 | input | 32 | Older instruction |
| pair_ins1 | input | 32 | Younger instruction |
| reg_busy | input | 128 | Scoreboard: register has an unresolved pending write |
| stall | output | 1 | Fetch must hold the current pair |
| ev_vld | output | 1 | Even path issue valid |
| ev_unit | output | 3 | Even path unit code |
| ev_rt | output | 7 | Even path destination / third source |
| ev_ra | output | 7 | Even path first source |
| ev_rb | output | 7 | Even path second source |
| ev_use_b | output | 1 | Even path reads second source |
| ev_use_c | output | 1 | Even path reads third source |
| ev_wr | output | 1 | Even path writes destination |
| od_vld | output | 1 | Odd path issue valid |
| od_unit | output | 3 | Odd path unit code |
| od_rt | output | 7 | Odd path destination / third source |
| od_ra | output | 7 | Odd path first source |
| od_rb | output | 7 | Odd path second source |
| od_use_b | output | 1 | Odd path reads second source |
| od_use_c | output | 1 | Odd path reads third source |
| od_wr | output | 1 | Odd path writes destination |

## Verification
The bench uses the package defaults: 128 registers with 7-bit indices and the 4/3 split of units between even and odd paths. In the random phase, register indices are drawn from only eight values. This makes scoreboard hits and dependencies inside a pair on each of the three source fields frequent. It also makes pairs that compete for one path frequent, and flushes that land while a split is pending. Directed cases cover skipped first slots, empty slots, and busy registers that are not used.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  localparam int INSTR_W        = 32;
  localparam int UNIT_W         = 3;
  localparam int REG_W          = 7;
  localparam int NUM_REGS       = 1 << REG_W;
  localparam int NUM_SLOTS      = 2;
  localparam int NUM_PATHS      = 2;
  localparam int LAST_EVEN_UNIT = 4;

  // field positions derived from the widths
  localparam int UNIT_LSB = INSTR_W - UNIT_W;
  localparam int RT_LSB   = UNIT_LSB - REG_W;
  localparam int RA_LSB   = RT_LSB - REG_W;
  localparam int RB_LSB   = RA_LSB - REG_W;
  localparam int USEB_BIT = RB_LSB - 1;
  localparam int USEC_BIT = USEB_BIT - 1;
  localparam int WR_BIT   = USEC_BIT - 1;

  typedef enum logic [UNIT_W-1:0] {
    U_NONE = 3'd0,
    U_FX1  = 3'd1,
    U_FX2  = 3'd2,
    U_SP   = 3'd3,
    U_BYTE = 3'd4,
    U_PERM = 3'd5,
    U_BR   = 3'd6,
    U_LS   = 3'd7
  } unit_e;

  typedef struct packed {
    unit_e            unit;
    logic             odd_path;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic             use_b;
    logic             use_c;
    logic             wr;
  } dec_t;

endpackage

// File: rtl/dsp_slot_decode.sv
module dsp_slot_decode
  import dsp_pkg::*;
(
  input  logic [INSTR_W-1:0] ins,
  output dec_t               dec
);

  logic unused_opbits;
  assign unused_opbits = ^ins[WR_BIT-1:0];

  always_comb begin
    dec.unit     = unit_e'(ins[UNIT_LSB +: UNIT_W]);
    dec.odd_path = (ins[UNIT_LSB +: UNIT_W] > UNIT_W'(LAST_EVEN_UNIT));
    dec.rt       = ins[RT_LSB +: REG_W];
    dec.ra       = ins[RA_LSB +: REG_W];
    dec.rb       = ins[RB_LSB +: REG_W];
    dec.use_b    = ins[USEB_BIT];
    dec.use_c    = ins[USEC_BIT];
    dec.wr       = ins[WR_BIT] && (ins[UNIT_LSB +: UNIT_W] != U_NONE);
  end

endmodule

// File: rtl/dsp_raw_check.sv
module dsp_raw_check
  import dsp_pkg::*;
(
  input  dec_t                cons,
  input  dec_t                prod,
  input  logic                prod_live,
  input  logic [NUM_REGS-1:0] reg_busy,
  output logic                sb_block,
  output logic                pair_dep
);

  logic hit_a, hit_b, hit_c;
  logic dep_a, dep_b, dep_c;

  always_comb begin
    hit_a    = reg_busy[cons.ra];
    hit_b    = cons.use_b && reg_busy[cons.rb];
    hit_c    = cons.use_c && reg_busy[cons.rt];
    sb_block = hit_a || hit_b || hit_c;

    dep_a    = (cons.ra == prod.rt);
    dep_b    = cons.use_b && (cons.rb == prod.rt);
    dep_c    = cons.use_c && (cons.rt == prod.rt);
    pair_dep = prod_live && prod.wr && (dep_a || dep_b || dep_c);
  end

  logic unused_prod;
  assign unused_prod = ^{prod.unit, prod.odd_path, prod.ra, prod.rb,
                         prod.use_b, prod.use_c};

endmodule

// File: rtl/dsp_issue_reg.sv
module dsp_issue_reg
  import dsp_pkg::*;
#(
  parameter bit ODD = 1'b0
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  dec_t             d_in,
  output logic             q_vld,
  output logic [UNIT_W-1:0] q_unit,
  output logic [REG_W-1:0] q_rt,
  output logic [REG_W-1:0] q_ra,
  output logic [REG_W-1:0] q_rb,
  output logic             q_use_b,
  output logic             q_use_c,
  output logic             q_wr
);

  logic vld_q, vld_d;
  dec_t pay_q, pay_d;

  always_comb begin
    vld_d = load;
    pay_d = load ? d_in : pay_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) pay_q <= pay_d;
  end

  assign q_vld   = vld_q;
  assign q_unit  = pay_q.unit;
  assign q_rt    = pay_q.rt;
  assign q_ra    = pay_q.ra;
  assign q_rb    = pay_q.rb;
  assign q_use_b = pay_q.use_b;
  assign q_use_c = pay_q.use_c;
  assign q_wr    = pay_q.wr;

  generate
    if (ODD) begin : g_odd_chk
      a_r2_odd_units: assert property (@(posedge clk) disable iff (!rst_n)
        q_vld |-> (q_unit > UNIT_W'(LAST_EVEN_UNIT)))
        else $error("odd path carries even unit");
    end else begin : g_even_chk
      a_r2_even_units: assert property (@(posedge clk) disable iff (!rst_n)
        q_vld |-> (q_unit != U_NONE) && (q_unit <= UNIT_W'(LAST_EVEN_UNIT)))
        else $error("even path carries odd or empty unit");
    end
  endgenerate

endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import dsp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                pair_vld,
  input  logic                pair_skip0,
  input  logic [INSTR_W-1:0]  pair_ins0,
  input  logic [INSTR_W-1:0]  pair_ins1,
  input  logic [NUM_REGS-1:0] reg_busy,
  output logic                stall,
  output logic                ev_vld,
  output logic [UNIT_W-1:0]   ev_unit,
  output logic [REG_W-1:0]    ev_rt,
  output logic [REG_W-1:0]    ev_ra,
  output logic [REG_W-1:0]    ev_rb,
  output logic                ev_use_b,
  output logic                ev_use_c,
  output logic                ev_wr,
  output logic                od_vld,
  output logic [UNIT_W-1:0]   od_unit,
  output logic [REG_W-1:0]    od_rt,
  output logic [REG_W-1:0]    od_ra,
  output logic [REG_W-1:0]    od_rb,
  output logic                od_use_b,
  output logic                od_use_c,
  output logic                od_wr
);

  logic [INSTR_W-1:0] slot_ins [NUM_SLOTS];
  dec_t               dec      [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] sb_blk, dep, live, go;

  assign slot_ins[0] = pair_ins0;
  assign slot_ins[1] = pair_ins1;

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      dsp_slot_decode u_dec (
        .ins (slot_ins[s]),
        .dec (dec[s])
      );
      dsp_raw_check u_raw (
        .cons      (dec[s]),
        .prod      (dec[0]),
        .prod_live ((s == 0) ? 1'b0 : live[0]),
        .reg_busy  (reg_busy),
        .sb_block  (sb_blk[s]),
        .pair_dep  (dep[s])
      );
    end
  endgenerate

  // split state: older slot of the held pair has already issued
  logic older_done_q, older_done_d;
  logic same_path, pair_done, stall_c;

  always_comb begin
    live[0]   = pair_vld && !pair_skip0 && !older_done_q && (dec[0].unit != U_NONE);
    live[1]   = pair_vld && (dec[1].unit != U_NONE);
    same_path = (dec[0].odd_path == dec[1].odd_path);
    go[0]     = live[0] && !sb_blk[0] && !flush;
    go[1]     = live[1] && !sb_blk[1] && !flush &&
                (!live[0] || (go[0] && !same_path && !dep[1]));
    pair_done = (!live[0] || go[0]) && (!live[1] || go[1]);
    stall_c   = pair_vld && !pair_done && !flush;
    older_done_d = stall_c ? (older_done_q || go[0]) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_done_q <= 1'b0;
    else        older_done_q <= older_done_d;
  end

  assign stall = stall_c;

  // path routing
  logic [NUM_PATHS-1:0] p_vld, p_use_b, p_use_c, p_wr;
  logic [UNIT_W-1:0]    p_unit [NUM_PATHS];
  logic [REG_W-1:0]     p_rt   [NUM_PATHS];
  logic [REG_W-1:0]     p_ra   [NUM_PATHS];
  logic [REG_W-1:0]     p_rb   [NUM_PATHS];

  genvar p;
  generate
    for (p = 0; p < NUM_PATHS; p++) begin : g_path
      logic take0, take1;
      dec_t sel;
      always_comb begin
        take0 = go[0] && (dec[0].odd_path == p[0]);
        take1 = go[1] && (dec[1].odd_path == p[0]);
        sel   = take0 ? dec[0] : dec[1];
      end

      dsp_issue_reg #(.ODD(p == 1)) u_iss (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take0 || take1),
        .d_in    (sel),
        .q_vld   (p_vld[p]),
        .q_unit  (p_unit[p]),
        .q_rt    (p_rt[p]),
        .q_ra    (p_ra[p]),
        .q_rb    (p_rb[p]),
        .q_use_b (p_use_b[p]),
        .q_use_c (p_use_c[p]),
        .q_wr    (p_wr[p])
      );

      a_r4_one_claim_per_path: assert property (@(posedge clk) disable iff (!rst_n)
        !(take0 && take1))
        else $error("two slots claim one path");
    end
  endgenerate

  assign ev_vld   = p_vld[0];
  assign ev_unit  = p_unit[0];
  assign ev_rt    = p_rt[0];
  assign ev_ra    = p_ra[0];
  assign ev_rb    = p_rb[0];
  assign ev_use_b = p_use_b[0];
  assign ev_use_c = p_use_c[0];
  assign ev_wr    = p_wr[0];
  assign od_vld   = p_vld[1];
  assign od_unit  = p_unit[1];
  assign od_rt    = p_rt[1];
  assign od_ra    = p_ra[1];
  assign od_rb    = p_rb[1];
  assign od_use_b = p_use_b[1];
  assign od_use_c = p_use_c[1];
  assign od_wr    = p_wr[1];

  a_r9_flush_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ev_vld && !od_vld)
    else $error("issue after flush");

  a_r10_stall_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> pair_vld)
    else $error("stall without pair");

  a_r3_distinct_units: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && od_vld) |-> (ev_unit != od_unit))
    else $error("same unit on both paths");

  a_r7_split_follows_stall: assert property (@(posedge clk) disable iff (!rst_n)
    older_done_q |-> $past(stall))
    else $error("split state without prior stall");

endmodule

// File: tb/dual_issue_dispatch_bench.sv
`timescale 1ns/1ps
module dual_issue_dispatch_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         flush, pair_vld, pair_skip0;
  logic [31:0]  pair_ins0, pair_ins1;
  logic [127:0] reg_busy;
  logic         stall;
  logic         ev_vld, ev_use_b, ev_use_c, ev_wr;
  logic [2:0]   ev_unit;
  logic [6:0]   ev_rt, ev_ra, ev_rb;
  logic         od_vld, od_use_b, od_use_c, od_wr;
  logic [2:0]   od_unit;
  logic [6:0]   od_rt, od_ra, od_rb;

  always #4 clk = ~clk;

  dual_issue_dispatch u_dual_issue_dispatch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pair_vld(pair_vld),
    .pair_skip0(pair_skip0), .pair_ins0(pair_ins0), .pair_ins1(pair_ins1),
    .reg_busy(reg_busy), .stall(stall),
    .ev_vld(ev_vld), .ev_unit(ev_unit), .ev_rt(ev_rt), .ev_ra(ev_ra),
    .ev_rb(ev_rb), .ev_use_b(ev_use_b), .ev_use_c(ev_use_c), .ev_wr(ev_wr),
    .od_vld(od_vld), .od_unit(od_unit), .od_rt(od_rt), .od_ra(od_ra),
    .od_rb(od_rb), .od_use_b(od_use_b), .od_use_c(od_use_c), .od_wr(od_wr)
  );

  int total = 0;
  int bad   = 0;
  logic        m_used;
  logic        exp_v   [2];
  logic [31:0] exp_ins [2];
  string       prev_tag;
  logic        done_flag = 1'b0;

  // R1 encoding helpers
  function automatic logic [31:0] mk(input int unit, input int rt, input int ra,
                                     input int rb, input bit ub, input bit uc,
                                     input bit wr);
    logic [31:0] w;
    w = '0;
    w[31:29] = unit[2:0];
    w[28:22] = rt[6:0];
    w[21:15] = ra[6:0];
    w[14:8]  = rb[6:0];
    w[7] = ub; w[6] = uc; w[5] = wr;
    return w;
  endfunction

  function automatic logic [26:0] pkt_of(input logic [31:0] w);
    return {w[31:29], w[28:22], w[21:15], w[14:8], w[7], w[6],
            w[5] && (w[31:29] != 3'd0)};
  endfunction

  function automatic bit busy_hit(input logic [31:0] w, input logic [127:0] bz);
    return bz[w[21:15]] || (w[7] && bz[w[14:8]]) || (w[6] && bz[w[28:22]]);
  endfunction

  function automatic bit reads_from(input logic [31:0] y, input logic [31:0] o);
    if (!(o[5] && o[31:29] != 3'd0)) return 1'b0;
    return (y[21:15] == o[28:22]) || (y[7] && y[14:8] == o[28:22]) ||
           (y[6] && y[28:22] == o[28:22]);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic check_paths();
    logic [26:0] a;
    a = {ev_unit, ev_rt, ev_ra, ev_rb, ev_use_b, ev_use_c, ev_wr};
    check((ev_vld === exp_v[0]) && (!exp_v[0] || a === pkt_of(exp_ins[0])),
          prev_tag, "even path", {4'(ev_vld), a}, {4'(exp_v[0]), pkt_of(exp_ins[0])});
    a = {od_unit, od_rt, od_ra, od_rb, od_use_b, od_use_c, od_wr};
    check((od_vld === exp_v[1]) && (!exp_v[1] || a === pkt_of(exp_ins[1])),
          prev_tag, "odd path", {4'(od_vld), a}, {4'(exp_v[1]), pkt_of(exp_ins[1])});
  endtask

  task automatic cyc(input logic [31:0] i0, input logic [31:0] i1, input bit v,
                     input bit sk, input bit fl, input logic [127:0] bz,
                     input string tag);
    bit a0, a1, g0, g1, same, fin, es;
    @(negedge clk);
    check_paths();
    pair_ins0 = i0; pair_ins1 = i1; pair_vld = v; pair_skip0 = sk;
    flush = fl; reg_busy = bz;
    #1;
    a0   = v && !sk && !m_used && (i0[31:29] != 3'd0);
    a1   = v && (i1[31:29] != 3'd0);
    same = (i0[31:29] > 3'd4) == (i1[31:29] > 3'd4);
    g0   = !fl && a0 && !busy_hit(i0, bz);
    g1   = !fl && a1 && !busy_hit(i1, bz) &&
           (!a0 || (g0 && !same && !reads_from(i1, i0)));
    fin  = (!a0 || g0) && (!a1 || g1);
    es   = v && !fin && !fl;
    exp_v[0] = 1'b0; exp_v[1] = 1'b0;
    if (g0) begin exp_v[i0[31:29] > 3'd4] = 1'b1; exp_ins[i0[31:29] > 3'd4] = i0; end
    if (g1) begin exp_v[i1[31:29] > 3'd4] = 1'b1; exp_ins[i1[31:29] > 3'd4] = i1; end
    m_used = es ? (m_used || g0) : 1'b0;
    check(stall === es, tag, "stall", {31'd0, stall}, {31'd0, es});
    prev_tag = tag;
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [31:0] x0, x1, fx, fy, pm, br;
    logic [127:0] bz;
    bit v, sk;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; flush = 0; pair_vld = 0; pair_skip0 = 0;
    pair_ins0 = '0; pair_ins1 = '0; reg_busy = '0;
    m_used = 0; exp_v[0] = 0; exp_v[1] = 0; exp_ins[0] = '0; exp_ins[1] = '0;
    prev_tag = "R11";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!ev_vld && !od_vld, "R11", "reset issue", {30'd0, ev_vld, od_vld}, 32'd0);
    check(stall === 1'b0, "R11", "reset stall", {31'd0, stall}, 32'd0);

    fx = mk(1, 10, 1, 2, 1, 0, 1);
    fy = mk(2, 12, 3, 4, 1, 0, 1);
    pm = mk(5, 11, 5, 6, 1, 0, 1);
    br = mk(6, 0, 7, 8, 0, 0, 0);

    // R1/R2: field routing, SP to even, LS to odd
    cyc(mk(3, 9, 1, 2, 1, 1, 1), mk(7, 4, 5, 6, 0, 0, 0), 1, 0, 0, '0, "R2");
    // R3: independent pair issues whole
    cyc(fx, pm, 1, 0, 0, '0, "R3");
    // R4: even conflict, then odd conflict
    cyc(fx, fy, 1, 0, 0, '0, "R4");
    cyc(fx, fy, 1, 0, 0, '0, "R4");
    cyc(pm, br, 1, 0, 0, '0, "R4");
    cyc(pm, br, 1, 0, 0, '0, "R4");
    // R5: dependency via first source, third source; no split when older does not write
    cyc(mk(1, 20, 1, 2, 0, 0, 1), mk(5, 30, 20, 3, 0, 0, 1), 1, 0, 0, '0, "R5");
    cyc(mk(1, 20, 1, 2, 0, 0, 1), mk(5, 30, 20, 3, 0, 0, 1), 1, 0, 0, '0, "R5");
    cyc(mk(1, 21, 1, 2, 0, 0, 1), mk(7, 21, 4, 3, 0, 1, 0), 1, 0, 0, '0, "R5");
    cyc(mk(1, 21, 1, 2, 0, 0, 1), mk(7, 21, 4, 3, 0, 1, 0), 1, 0, 0, '0, "R5");
    cyc(mk(1, 22, 1, 2, 0, 0, 0), mk(5, 30, 22, 3, 0, 0, 1), 1, 0, 0, '0, "R5");
    // R6: busy first source blocks; unused second source ignored; used third blocks
    bz = '0; bz[1] = 1'b1;
    cyc(fx, pm, 1, 0, 0, bz, "R6");
    cyc(fx, pm, 1, 0, 0, '0, "R6");
    bz = '0; bz[40] = 1'b1;
    cyc(mk(1, 10, 1, 40, 0, 0, 1), pm, 1, 0, 0, bz, "R6");
    bz = '0; bz[33] = 1'b1;
    cyc(mk(4, 33, 1, 2, 0, 1, 1), pm, 1, 0, 0, bz, "R6");
    cyc(mk(4, 33, 1, 2, 0, 1, 1), pm, 1, 0, 0, '0, "R6");
    // R7: older blocked, younger free on other path still waits
    bz = '0; bz[2] = 1'b1;
    cyc(fx, pm, 1, 0, 0, bz, "R7");
    cyc(fx, pm, 1, 0, 0, bz, "R7");
    cyc(fx, pm, 1, 0, 0, '0, "R7");
    // R8: skipped first slot
    cyc(fx, fy, 1, 1, 0, '0, "R8");
    cyc(pm, br, 1, 1, 0, '0, "R8");
    // R9: flush during split, then same pair decided afresh
    cyc(fx, fy, 1, 0, 0, '0, "R9");
    cyc(fx, fy, 1, 0, 1, '0, "R9");
    cyc(fx, fy, 1, 0, 0, '0, "R9");
    cyc(fx, fy, 1, 0, 0, '0, "R9");
    // R10: empty slots and invalid pair
    cyc(32'd0, 32'd0, 1, 0, 0, '0, "R10");
    cyc(32'd0, br, 1, 0, 0, '0, "R10");
    cyc(fx, fy, 0, 0, 0, '0, "R10");
    cyc(32'd0, 32'd0, 0, 0, 0, '0, "R10");

    // random phase
    x0 = '0; x1 = '0; v = 0; sk = 0;
    for (int n = 0; n < 4000; n++) begin
      bit fl;
      if (!stall) begin
        x0 = $urandom; x1 = $urandom;
        x0[28:8] = {4'd0, 3'($urandom_range(0, 7)), 4'd0, 3'($urandom_range(0, 7)),
                    4'd0, 3'($urandom_range(0, 7))};
        x1[28:8] = {4'd0, 3'($urandom_range(0, 7)), 4'd0, 3'($urandom_range(0, 7)),
                    4'd0, 3'($urandom_range(0, 7))};
        v  = ($urandom_range(0, 7) != 0);
        sk = ($urandom_range(0, 7) == 0);
      end
      bz = '0;
      for (int r = 0; r < 8; r++) bz[r] = ($urandom_range(0, 5) == 0);
      fl = ($urandom_range(0, 19) == 0);
      cyc(x0, x1, v, sk, fl, bz, "R7");
    end
    cyc(32'd0, 32'd0, 0, 0, 0, '0, "R7");
    @(negedge clk);
    check_paths();
    done_flag = 1'b1;
    finish_up();
  end

endmodule